// File: doc/BRIEF.md
# Byte-Programmed SPI Sequencer

This block is a half-duplex SPI master whose transfers are steered by a short program. The program is eight one-byte instructions packed into a 64-bit register. Software loads the program, a loop count, a clock divider and transmit words through a small register port. The sequencer then walks the program one slot at a time. It can assert a chip select, shift bytes out of a transmit holding register, shift bytes into a receive holding register, copy the transmit word straight into the receive register, and jump back to an earlier slot while a loop counter lasts.

The two holding registers each carry a full flag. They are the hand-off point between software and the sequencer. A shift-out group waits until a transmit word is present. A shift-in group waits until the previous receive word has been read, so no received byte is ever overwritten. Misuse is recorded in sticky flags: a write to a full transmit register, or a read of an empty receive register. These flags are cleared only by a two-step reset written through the clock configuration register.

The register port is a request/response stream. `req_ready` is held high, so a request is accepted in every cycle in which `req_valid` is high. A read answers exactly one cycle later with `rsp_valid` high for one cycle. The response side has no back-pressure, so the requester must take the response in that cycle.

Top module: `seqspi_engine`

## Requirements
- R1: `req_ready` is always 1. Every read request is answered one clock later with `rsp_valid`=1 and the data. Register addresses: 0 program, 1 loop config, 2 clock config, 3 transmit data, 4 receive data, 5 status.
- R2: A program write while idle starts execution at slot 0 (bits 63:56), then continues toward bits 7:0. Execution ends on opcode 0x00 or after slot 7. Status bits 55:48 are one-hot: 48 idle, 49 decode, 50 shift-out, 51 shift-in, 52 copy.
- R3: Opcode 0x1N drives `cs_n[N-1]` low and every other line high. N=0, or N above the number of lines, selects nothing. All lines go high when the program ends.
- R4: Opcode 0x3N (N=1..8) waits for the transmit register to be full. It then sends its N most significant bytes, MSB first, each byte bit 7 first on `mosi`. The transmit full flag (status bit 59) clears when the word is taken.
- R5: Opcode 0x4N (N=1..8) waits while the receive register is full, then shifts in N bytes. The last byte lands in bits 7:0, earlier bytes sit above it, and the unused upper bytes are zero. The receive full flag (bit 63) then sets, and reading address 4 clears it.
- R6: SCK idles low. Data is sampled on its rising edge and changes on its falling edge. Its period is 2×(D+1) clocks, where D is clock config bits 63:52.
- R7: Opcode 0xEN (N=0..7) jumps to slot N while the loop count is non-zero, and decrements the count on each jump. The loop count is taken from loop config bits 39:32 at program start, so a count of L runs the loop body L+1 times.
- R8: A transmit write while the register is full sets overrun (status bit 58) and keeps the old word. A receive read while the register is empty sets underrun (status bit 61).
- R9: Opcode 0xC0 waits for a full transmit register and an empty receive register. It then moves the transmit word into the receive register.
- R10: Any undefined opcode sets status bit 12 and returns the sequencer to idle.
- R11: Two consecutive clock-config writes, the first with bits 36 and 38 set and the second with bits 37 and 39 set, clear both full flags and all sticky flags and force the sequencer idle.
- R12: A program write while the sequencer is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_data | output | 64 | Read data |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench places a shift-in after a shift-out and checks which `miso` bits end up in the receive word. A design that sampled on the wrong SCK edge, or packed bytes in the wrong order, would return a shifted or byte-swapped value. A three-pass loop is checked by counting the SCK rising edges and the transmitted bytes, which exposes an off-by-one in the loop count. Two back-to-back shift-in groups test that the second group waits for the first word to be read; without that wait, the first byte would be lost. The bench also checks that a program written mid-run is ignored, that a rejected transmit write keeps the old word, that the sequencer stops after slot 7 and on an undefined opcode, and that a single clock-config write does not trigger the reset.

// File: rtl/seqspi_pkg.sv
package seqspi_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] A_PROG = 3'd0;
  localparam logic [REG_AW-1:0] A_LOOP = 3'd1;
  localparam logic [REG_AW-1:0] A_CLK  = 3'd2;
  localparam logic [REG_AW-1:0] A_TXD  = 3'd3;
  localparam logic [REG_AW-1:0] A_RXD  = 3'd4;
  localparam logic [REG_AW-1:0] A_STAT = 3'd5;

  localparam int LOOP_LSB   = 32;
  localparam int ST_RX_FULL = 63;
  localparam int ST_RX_UND  = 61;
  localparam int ST_TX_FULL = 59;
  localparam int ST_TX_OVR  = 58;
  localparam int ST_STATE   = 48;
  localparam int ST_BADOP   = 12;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_OUT_WAIT, SQ_OUT_BYTE,
    SQ_IN_WAIT, SQ_IN_BYTE, SQ_COPY
  } sq_state_e;
endpackage

// File: rtl/seqspi_shifter.sv
module seqspi_shifter #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte
);
  logic [DIV_W-1:0] half_cnt;
  logic [2:0]       bit_idx;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      busy     <= 1'b0;
      sck      <= 1'b0;
      done     <= 1'b0;
      half_cnt <= '0;
      bit_idx  <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy     <= 1'b1;
        sck      <= 1'b0;
        half_cnt <= '0;
        bit_idx  <= '0;
        tx_sh    <= tx_byte;
      end else if (busy) begin
        if (half_cnt == div) begin
          half_cnt <= '0;
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_idx == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end
          end
        end else begin
          half_cnt <= half_cnt + DIV_W'(1);
        end
      end
    end
  end

  assign mosi    = busy & tx_sh[7];
  assign rx_byte = rx_sh;

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);  // R6
  AST_START_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);  // R6
endmodule

// File: rtl/seqspi_sequencer.sv
module seqspi_sequencer
  import seqspi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [63:0]      prog,
  input  logic [CNT_W-1:0] loops,
  input  logic             tdr_full,
  input  logic [63:0]      tdr_data,
  input  logic             rdr_full,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             sh_start,
  output logic [7:0]       sh_byte,
  output logic             tdr_take,
  output logic             rdr_load,
  output logic [63:0]      rdr_data,
  output logic [3:0]       cs_sel,
  output logic [7:0]       state_bits,
  output logic             bad_op
);
  sq_state_e        st;
  logic [3:0]       pc;
  logic [3:0]       cnt;
  logic [CNT_W-1:0] loops_left;
  logic [63:0]      tx_hold;
  logic [55:0]      rx_acc;
  logic [5:0]       op_sh;
  logic [7:0]       op;
  logic             copy_go;
  logic             len_ok;

  assign op_sh   = {~pc[2:0], 3'b000};
  assign op      = prog[op_sh +: 8];
  assign len_ok  = (op[3:0] != 4'd0) && (op[3:0] <= 4'd8);
  assign copy_go = (st == SQ_COPY) && tdr_full && !rdr_full;

  assign tdr_take = ((st == SQ_OUT_WAIT) && tdr_full) || copy_go;
  assign rdr_load = ((st == SQ_IN_BYTE) && sh_done && (cnt == 4'd1)) || copy_go;
  assign rdr_data = (st == SQ_COPY) ? tdr_data : {rx_acc, sh_rx};

  always_comb begin
    unique case (st)
      SQ_IDLE:                  state_bits = 8'h01;
      SQ_FETCH:                 state_bits = 8'h02;
      SQ_OUT_WAIT, SQ_OUT_BYTE: state_bits = 8'h04;
      SQ_IN_WAIT, SQ_IN_BYTE:   state_bits = 8'h08;
      default:                  state_bits = 8'h10;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      st         <= SQ_IDLE;
      pc         <= '0;
      cnt        <= '0;
      loops_left <= '0;
      tx_hold    <= '0;
      rx_acc     <= '0;
      cs_sel     <= '0;
      sh_start   <= 1'b0;
      sh_byte    <= '0;
      bad_op     <= 1'b0;
    end else begin
      sh_start <= 1'b0;
      bad_op   <= 1'b0;
      unique case (st)
        SQ_IDLE: if (start) begin
          pc         <= '0;
          loops_left <= loops;
          st         <= SQ_FETCH;
        end
        SQ_FETCH: begin
          if (pc[3]) begin
            st     <= SQ_IDLE;
            cs_sel <= '0;
          end else begin
            unique case (op[7:4])
              4'h0: begin
                st     <= SQ_IDLE;
                cs_sel <= '0;
                bad_op <= (op[3:0] != 4'd0);
              end
              4'h1: begin
                cs_sel <= op[3:0];
                pc     <= pc + 4'd1;
              end
              4'h3, 4'h4: begin
                if (len_ok) begin
                  cnt    <= op[3:0];
                  rx_acc <= '0;
                  st     <= op[6] ? SQ_IN_WAIT : SQ_OUT_WAIT;
                end else begin
                  st     <= SQ_IDLE;
                  cs_sel <= '0;
                  bad_op <= 1'b1;
                end
              end
              4'hC: begin
                if (op[3:0] == 4'd0) st <= SQ_COPY;
                else begin
                  st     <= SQ_IDLE;
                  cs_sel <= '0;
                  bad_op <= 1'b1;
                end
              end
              4'hE: begin
                if (op[3]) begin
                  st     <= SQ_IDLE;
                  cs_sel <= '0;
                  bad_op <= 1'b1;
                end else if (loops_left != '0) begin
                  loops_left <= loops_left - CNT_W'(1);
                  pc         <= {1'b0, op[2:0]};
                end else begin
                  pc <= pc + 4'd1;
                end
              end
              default: begin
                st     <= SQ_IDLE;
                cs_sel <= '0;
                bad_op <= 1'b1;
              end
            endcase
          end
        end
        SQ_OUT_WAIT: if (tdr_full) begin
          sh_byte  <= tdr_data[63:56];
          tx_hold  <= {tdr_data[55:0], 8'h00};
          sh_start <= 1'b1;
          st       <= SQ_OUT_BYTE;
        end
        SQ_OUT_BYTE: if (sh_done) begin
          if (cnt == 4'd1) begin
            pc <= pc + 4'd1;
            st <= SQ_FETCH;
          end else begin
            cnt      <= cnt - 4'd1;
            sh_byte  <= tx_hold[63:56];
            tx_hold  <= {tx_hold[55:0], 8'h00};
            sh_start <= 1'b1;
          end
        end
        SQ_IN_WAIT: if (!rdr_full) begin
          sh_byte  <= 8'h00;
          sh_start <= 1'b1;
          st       <= SQ_IN_BYTE;
        end
        SQ_IN_BYTE: if (sh_done) begin
          rx_acc <= {rx_acc[47:0], sh_rx};
          if (cnt == 4'd1) begin
            pc <= pc + 4'd1;
            st <= SQ_FETCH;
          end else begin
            cnt      <= cnt - 4'd1;
            sh_start <= 1'b1;
          end
        end
        default: if (copy_go) begin
          pc <= pc + 4'd1;
          st <= SQ_FETCH;
        end
      endcase
    end
  end

  AST_STATE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_bits) == 1);  // R2
  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_IDLE) |-> (cs_sel == 4'd0));  // R3
endmodule

// File: rtl/seqspi_engine.sv
module seqspi_engine
  import seqspi_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 12,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [2:0]        req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int DIV_MSB = 63;

  logic [63:0] prog_q, loop_q, clk_q, tdr_q, rdr_q, stat_w, rd_mux;
  logic        tdr_full, rdr_full, tx_ovr, rx_und, err_op, armed;
  logic        wr_en, rd_en, soft_rst, start;
  logic        sh_start, sh_busy, sh_done, tdr_take, rdr_load, bad_op;
  logic [7:0]  sh_byte, sh_rx, state_bits;
  logic [63:0] rdr_data;
  logic [3:0]  cs_sel;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid && req_write;
  assign rd_en     = req_valid && !req_write;
  assign soft_rst  = wr_en && (req_addr == A_CLK) && armed
                     && req_wdata[37] && req_wdata[39];
  assign start     = wr_en && (req_addr == A_PROG) && state_bits[0];

  always_comb begin
    stat_w                       = '0;
    stat_w[ST_RX_FULL]           = rdr_full;
    stat_w[ST_RX_UND]            = rx_und;
    stat_w[ST_TX_FULL]           = tdr_full;
    stat_w[ST_TX_OVR]            = tx_ovr;
    stat_w[ST_STATE +: 8]        = state_bits;
    stat_w[ST_BADOP]             = err_op;
  end

  always_comb begin
    unique case (req_addr)
      A_PROG:  rd_mux = prog_q;
      A_LOOP:  rd_mux = loop_q;
      A_CLK:   rd_mux = clk_q;
      A_TXD:   rd_mux = tdr_q;
      A_RXD:   rd_mux = rdr_q;
      A_STAT:  rd_mux = stat_w;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      prog_q    <= '0;
      loop_q    <= '0;
      clk_q     <= '0;
      tdr_q     <= '0;
      rdr_q     <= '0;
      tdr_full  <= 1'b0;
      rdr_full  <= 1'b0;
      tx_ovr    <= 1'b0;
      rx_und    <= 1'b0;
      err_op    <= 1'b0;
      armed     <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
      if (wr_en && req_addr == A_LOOP) loop_q <= req_wdata;
      if (start) prog_q <= req_wdata;
      if (wr_en && req_addr == A_CLK) begin
        clk_q <= req_wdata;
        armed <= req_wdata[36] && req_wdata[38];
      end
      if (soft_rst) begin
        tdr_full <= 1'b0;
        rdr_full <= 1'b0;
        tx_ovr   <= 1'b0;
        rx_und   <= 1'b0;
        err_op   <= 1'b0;
        armed    <= 1'b0;
      end else begin
        if (tdr_take) tdr_full <= 1'b0;
        if (wr_en && req_addr == A_TXD) begin
          if (tdr_full) tx_ovr <= 1'b1;
          else begin
            tdr_q    <= req_wdata;
            tdr_full <= 1'b1;
          end
        end
        if (rd_en && req_addr == A_RXD) begin
          if (rdr_full) rdr_full <= 1'b0;
          else          rx_und   <= 1'b1;
        end
        if (rdr_load) begin
          rdr_q    <= rdr_data;
          rdr_full <= 1'b1;
        end
        if (bad_op) err_op <= 1'b1;
      end
    end
  end

  seqspi_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (soft_rst),
    .start      (start),
    .prog       (prog_q),
    .loops      (loop_q[LOOP_LSB +: CNT_W]),
    .tdr_full   (tdr_full),
    .tdr_data   (tdr_q),
    .rdr_full   (rdr_full),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx),
    .sh_start   (sh_start),
    .sh_byte    (sh_byte),
    .tdr_take   (tdr_take),
    .rdr_load   (rdr_load),
    .rdr_data   (rdr_data),
    .cs_sel     (cs_sel),
    .state_bits (state_bits),
    .bad_op     (bad_op)
  );

  seqspi_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (soft_rst),
    .start   (sh_start),
    .tx_byte (sh_byte),
    .div     (clk_q[DIV_MSB -: DIV_W]),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = (cs_sel != 4'(g + 1));
  end

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));  // R3
  AST_RX_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load |-> !rdr_full);  // R5
  AST_TX_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    tdr_take |-> tdr_full);  // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ovr && !soft_rst) |=> tx_ovr);  // R8
  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);  // R1
endmodule

// File: tb/seqspi_engine_bench.sv
`timescale 1ns/1ps
module seqspi_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [2:0]  req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic        req_ready, rsp_valid, sck, mosi, miso;
  logic [63:0] rsp_data;
  logic [3:0]  cs_n;

  int total = 0;
  int bad = 0;

  logic [63:0] pat = '0;
  int          fall_base = 0;
  int          fall_cnt = 0;
  int          rise_cnt = 0;
  int          rel;
  logic [63:0] mon = '0;
  time         t_last = 0;
  time         t_prev = 0;

  localparam logic [63:0] IDLE_ST = 64'h0001_0000_0000_0000;

  always #2 clk = ~clk;

  seqspi_engine u_seqspi_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  assign rel  = fall_cnt - fall_base;
  assign miso = (rel >= 0 && rel < 64) ? pat[63 - rel] : 1'b0;

  always @(negedge sck) fall_cnt <= fall_cnt + 1;
  always @(posedge sck) begin
    mon      <= {mon[62:0], mosi};
    rise_cnt <= rise_cnt + 1;
    t_prev   <= t_last;
    t_last   <= $time;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!rsp_valid) begin
      total++; bad++;
      $display("FAIL R1 act=%h exp=%h", rsp_valid, 1'b1);
    end
    d = rsp_data;
  endtask

  task automatic wait_bit(input int pos, input logic val, input string req);
    logic [63:0] s;
    bit hit = 1'b0;
    for (int i = 0; i < 3000 && !hit; i++) begin
      rd(3'd5, s);
      hit = (s[pos] == val);
    end
    chk(hit, req, {63'd0, s[pos]}, {63'd0, val});
  endtask

  task automatic wait_idle(input string req);
    logic [63:0] s;
    bit hit = 1'b0;
    for (int i = 0; i < 3000 && !hit; i++) begin
      rd(3'd5, s);
      hit = (s[55:48] == 8'h01);
    end
    chk(hit, req, {56'd0, s[55:48]}, 64'h01);
  endtask

  task automatic soft_reset();
    wr(3'd2, (64'd1 << 36) | (64'd1 << 38));
    wr(3'd2, (64'd1 << 37) | (64'd1 << 39));
    wr(3'd2, 64'd1 << 52);
  endtask

  task automatic t_reset();
    logic [63:0] s;
    chk(req_ready == 1'b1, "R1 ready", {63'd0, req_ready}, 64'd1);
    chk(cs_n == 4'hF && sck == 1'b0, "R3 reset pins", {59'd0, sck, cs_n}, 64'hF);
    rd(3'd5, s);
    chk(s == IDLE_ST, "R2 reset status", s, IDLE_ST);
  endtask

  task automatic t_out_in();
    logic [63:0] s;
    int r0;
    wr(3'd2, 64'd1 << 52);
    pat = 64'hA5C3_1E7F_0123_4567;
    fall_base = fall_cnt;
    r0 = rise_cnt;
    wr(3'd0, 64'h1132_4310_0000_0000);
    repeat (4) @(negedge clk);
    chk(cs_n == 4'b1110, "R3 select 1", {60'd0, cs_n}, 64'hE);
    chk(rise_cnt == r0, "R4 waits for tx word", rise_cnt - r0, 0);
    wr(3'd3, 64'hDEAD_BEEF_0BAD_F00D);
    wait_idle("R2 end on stop");
    chk(cs_n == 4'hF, "R3 deselect", {60'd0, cs_n}, 64'hF);
    chk(mon[39:24] == 16'hDEAD, "R4 mosi bytes", {48'd0, mon[39:24]}, 64'hDEAD);
    chk(rise_cnt - r0 == 40, "R4 bit count", rise_cnt - r0, 40);
    chk(t_last - t_prev == 16, "R6 sck period", t_last - t_prev, 16);
    rd(3'd5, s);
    chk(s[63] && !s[59], "R5 rx full tx empty", s, 64'h8001_0000_0000_0000);
    rd(3'd4, s);
    chk(s == 64'h1E7F01, "R5 rx packing", s, 64'h1E7F01);
    rd(3'd5, s);
    chk(s == IDLE_ST, "R5 read clears full", s, IDLE_ST);
  endtask

  task automatic t_loop();
    int r0;
    logic [63:0] words [3];
    words[0] = 64'hAA00_0000_0000_0000;
    words[1] = 64'h5500_0000_0000_0000;
    words[2] = 64'h3C00_0000_0000_0000;
    r0 = rise_cnt;
    wr(3'd1, 64'd2 << 32);
    wr(3'd0, 64'h1231_E110_0000_0000);
    for (int k = 0; k < 3; k++) begin
      wait_bit(59, 1'b0, "R7 tx drained");
      wr(3'd3, words[k]);
      if (k == 1) chk(cs_n == 4'b1101, "R3 select 2", {60'd0, cs_n}, 64'hD);
    end
    wait_idle("R7 loop ends");
    chk(rise_cnt - r0 == 24, "R7 three passes", rise_cnt - r0, 24);
    chk(mon[23:0] == 24'hAA553C, "R7 loop data", {40'd0, mon[23:0]}, 64'hAA553C);
    wr(3'd1, 64'd0);
  endtask

  task automatic t_overrun();
    logic [63:0] s;
    wr(3'd3, 64'h1100_0000_0000_0000);
    wr(3'd3, 64'h2200_0000_0000_0000);
    rd(3'd5, s);
    chk(s[58] && s[59], "R8 overrun flag", s, 64'h0C01_0000_0000_0000);
    wr(3'd0, 64'h3100_0000_0000_0000);
    wait_idle("R8 idle");
    chk(mon[7:0] == 8'h11, "R8 old word kept", {56'd0, mon[7:0]}, 64'h11);
    rd(3'd4, s);
    rd(3'd5, s);
    chk(s[61] == 1'b1, "R8 underrun flag", s, 64'h2401_0000_0000_0000);
  endtask

  task automatic t_soft_reset();
    logic [63:0] s;
    wr(3'd3, 64'h77);
    wr(3'd2, (64'd1 << 36) | (64'd1 << 38));
    rd(3'd5, s);
    chk(s[61] && s[59], "R11 first step alone", s, 64'h2C01_0000_0000_0000);
    wr(3'd2, (64'd1 << 37) | (64'd1 << 39));
    rd(3'd5, s);
    chk(s == IDLE_ST, "R11 cleared", s, IDLE_ST);
    wr(3'd2, 64'd1 << 52);
  endtask

  task automatic t_copy();
    logic [63:0] s;
    wr(3'd0, 64'hC000_0000_0000_0000);
    wr(3'd3, 64'h0123_4567_89AB_CDEF);
    wait_idle("R9 idle");
    rd(3'd4, s);
    chk(s == 64'h0123_4567_89AB_CDEF, "R9 copy", s, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_slot_end();
    logic [63:0] s;
    wr(3'd0, 64'h1010_1010_1010_1011);
    repeat (20) @(negedge clk);
    rd(3'd5, s);
    chk(s == IDLE_ST, "R2 end after slot 7", s, IDLE_ST);
    chk(cs_n == 4'hF, "R3 deselect at end", {60'd0, cs_n}, 64'hF);
  endtask

  task automatic t_bad_op();
    logic [63:0] s;
    wr(3'd0, 64'h1170_0000_0000_0000);
    repeat (10) @(negedge clk);
    rd(3'd5, s);
    chk(s[12] && s[55:48] == 8'h01, "R10 bad opcode", s, IDLE_ST | 64'h1000);
    soft_reset();
  endtask

  task automatic t_rx_stall();
    logic [63:0] s;
    int r0;
    pat = 64'h964B_0000_0000_0000;
    fall_base = fall_cnt;
    r0 = rise_cnt;
    wr(3'd0, 64'h4141_0000_0000_0000);
    wait_bit(63, 1'b1, "R5 first word");
    repeat (30) @(negedge clk);
    rd(3'd5, s);
    chk(s[55:48] == 8'h08 && rise_cnt - r0 == 8, "R5 stall on full",
        {32'd0, s[55:48], 24'(rise_cnt - r0)}, 64'h0800_0008);
    wr(3'd0, 64'h3100_0000_0000_0000);
    rd(3'd4, s);
    chk(s == 64'h96, "R5 first byte", s, 64'h96);
    wait_idle("R12 idle");
    rd(3'd4, s);
    chk(s == 64'h4B, "R12 busy write ignored", s, 64'h4B);
    chk(rise_cnt - r0 == 16, "R12 no extra shift", rise_cnt - r0, 16);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_out_in();
    t_loop();
    t_overrun();
    t_soft_reset();
    t_copy();
    t_slot_end();
    t_bad_op();
    t_rx_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule